// File: doc/BRIEF.md
# Clock source switch controller

This block chooses which of three oscillators drives the system clock: a primary oscillator (optionally followed by a frequency-multiplying PLL), a secondary oscillator, or an internal RC oscillator. Software writes a two-bit source field. The controller enables the requested oscillator and counts its start-up periods. When the PLL is in use, it also waits out a lock interval. Only then does it order a glitch-free clock mux to change over. The clock already in use keeps driving the system for the whole wait, so code keeps running.

The controller is clocked by the internal RC clock, which is always present in its own domain. Raw oscillator ticks arrive asynchronously and pass through synchronizers. A `src_rc_en` output reports whether the RC oscillator is needed as a system clock source. It is also held high whenever the watchdog or the clock-failure monitor is enabled. The mux is modelled as a select bus plus a one-cycle hand-over strobe. The mux answers with a completion pulse. The block never writes the source field; it only reads it.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is asserted and on release, `mux_sel` is 2'b10 (RC), `pri_stable` is 0, `handover` is 0, `src_rc_en` is 1, and `pri_osc_en` and `sec_osc_en` are 0.
- R2: `src_sel` decodes as 2'b00 = primary, 2'b01 = secondary, 2'b1x = RC. When bit 1 is set, bit 0 has no effect. `mux_sel` uses the codes 00 primary, 01 secondary, 10 RC.
- R3: A request for RC accepted outside a hand-over drops `pri_osc_en` and clears `pri_stable` one clock after it is sampled. A request for the primary or the secondary enables that oscillator one clock after it is sampled, while `mux_sel` keeps its old value.
- R4: A hand-over to the primary or the secondary is strobed only after OST_CYC synchronized rising edges of that oscillator's tick. Until then, the current source and `pri_stable` are left unchanged.
- R5: When `pll_use` is high at the start of a switch to the primary, `pll_en` follows `pri_osc_en`. The hand-over then waits a further PLL_LOCK_CYC controller cycles after the start-up count.
- R6: `handover` is a single-cycle pulse. `mux_sel` takes the new target at the end of that cycle and changes at no other time.
- R7: `pri_stable` rises only in the cycle after `mux_done` completes a hand-over to the primary. It is cleared by any hand-over to another source.
- R8: `src_rc_en` is high whenever `wdt_en` or `fscm_en` is high, and whenever RC is the current or the requested source. Otherwise it is low.
- R9: A new request during start-up or lock restarts the count from zero toward the new target. A request back to the source already in use cancels the switch without a hand-over.
- R10: A change of `src_sel` while the mux is finishing a hand-over is taken up after `mux_done`, as a fresh switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock (internal RC domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Requested clock source field |
| pll_use | input | 1 | Run the primary through the PLL |
| wdt_en | input | 1 | Watchdog enabled (needs the RC oscillator) |
| fscm_en | input | 1 | Clock-failure monitor enabled (needs the RC oscillator) |
| pri_tick | input | 1 | Raw asynchronous tick of the primary oscillator |
| sec_tick | input | 1 | Raw asynchronous tick of the secondary oscillator |
| mux_done | input | 1 | Clock mux reports that the change-over is complete |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| pll_en | output | 1 | PLL enable |
| src_rc_en | output | 1 | RC oscillator required as source or by a monitor |
| mux_sel | output | 2 | Select code to the glitch-free clock mux |
| handover | output | 1 | One-cycle strobe ordering the mux to change over |
| pri_stable | output | 1 | System runs on a counted-stable primary clock |

## Verification
On every cycle, the assertions check the following: the select bus moves only on the strobe, and the strobe lasts one cycle. They check that the stable flag implies a primary selection and follows a mux completion. They check that a monitor enable keeps the RC source required, and that an RC request turns the primary off at once. Only the bench scenarios can show the rest. These are the start-up edge count and the PLL lock delay measured against the oscillator ticks, the restart of the count after a mid-way retarget, the cancel that returns without any strobe, and a request deferred across a mux hand-over.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [1:0] {
    SRC_PRI = 2'b00,
    SRC_SEC = 2'b01,
    SRC_RC  = 2'b10
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_LOCK  = 3'd2,
    ST_HAND  = 3'd3,
    ST_WAIT  = 3'd4
  } st_e;

  localparam int NUM_OSC = 2;

  function automatic src_e decode_src(input logic [1:0] field);
    if (field[1]) return SRC_RC;
    else if (field[0]) return SRC_SEC;
    else return SRC_PRI;
  endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/clksw_timer.sv
module clksw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = inc && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= hit ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int OST_CYC      = 1024,
  parameter int PLL_LOCK_CYC = 16000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       pll_use,
  input  logic       wdt_en,
  input  logic       fscm_en,
  input  logic       pri_tick,
  input  logic       sec_tick,
  input  logic       mux_done,
  output logic       pri_osc_en,
  output logic       sec_osc_en,
  output logic       pll_en,
  output logic       src_rc_en,
  output logic [1:0] mux_sel,
  output logic       handover,
  output logic       pri_stable
);
  localparam int MAXC = (OST_CYC > PLL_LOCK_CYC) ? OST_CYC : PLL_LOCK_CYC;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] OST_LIM = W'(OST_CYC);
  localparam logic [W-1:0] PLL_LIM = W'(PLL_LOCK_CYC);

  st_e  state, st_n;
  src_e target, tgt_n, active, act_n, sel_q, sel_n, want;
  logic pll_q, pll_n, stab_q, stab_n, tmr_clr, tmr_inc, tmr_hit, tgt_edge;
  logic [W-1:0] tmr_lim;
  logic [NUM_OSC-1:0] raw_tick, tick_rise;

  assign want     = decode_src(src_sel);
  assign raw_tick = {sec_tick, pri_tick};

  // one synchronizer plus edge detector per counted oscillator
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
    clksw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(raw_tick[g]),
      .rise    (tick_rise[g])
    );
  end

  always_comb begin
    case (target)
      SRC_PRI: tgt_edge = tick_rise[0];
      SRC_SEC: tgt_edge = tick_rise[1];
      default: tgt_edge = 1'b0;
    endcase
  end

  assign tmr_inc = (state == ST_START) ? tgt_edge : (state == ST_LOCK);
  assign tmr_lim = (state == ST_LOCK) ? PLL_LIM : OST_LIM;

  clksw_timer #(.W(W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .inc  (tmr_inc),
    .limit(tmr_lim),
    .hit  (tmr_hit)
  );

  always_comb begin
    st_n    = state;
    tgt_n   = target;
    act_n   = active;
    sel_n   = sel_q;
    pll_n   = pll_q;
    stab_n  = stab_q;
    tmr_clr = 1'b0;
    case (state)
      ST_IDLE, ST_START, ST_LOCK: begin
        if (want != target) begin
          // retarget: restart the sequence toward the new request
          tgt_n   = want;
          tmr_clr = 1'b1;
          if (want == active) begin
            st_n = ST_IDLE;
          end else if (want == SRC_RC) begin
            st_n   = ST_HAND;
            stab_n = 1'b0;
          end else begin
            st_n = ST_START;
            if (want == SRC_PRI) pll_n = pll_use;
          end
        end else if (state == ST_START && tmr_hit) begin
          tmr_clr = 1'b1;
          st_n    = (pll_q && target == SRC_PRI) ? ST_LOCK : ST_HAND;
        end else if (state == ST_LOCK && tmr_hit) begin
          tmr_clr = 1'b1;
          st_n    = ST_HAND;
        end
      end
      ST_HAND: begin
        sel_n = target;
        st_n  = ST_WAIT;
        if (target != SRC_PRI) stab_n = 1'b0;
      end
      ST_WAIT: begin
        if (mux_done) begin
          act_n  = target;
          st_n   = ST_IDLE;
          stab_n = (target == SRC_PRI);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      target <= SRC_RC;
      active <= SRC_RC;
      sel_q  <= SRC_RC;
      pll_q  <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      state  <= st_n;
      target <= tgt_n;
      active <= act_n;
      sel_q  <= sel_n;
      pll_q  <= pll_n;
      stab_q <= stab_n;
    end
  end

  assign handover   = (state == ST_HAND);
  assign mux_sel    = sel_q;
  assign pri_stable = stab_q;
  assign pri_osc_en = (target == SRC_PRI) || (active == SRC_PRI && target != SRC_RC);
  assign sec_osc_en = (target == SRC_SEC) || (active == SRC_SEC);
  assign pll_en     = pri_osc_en && pll_q;
  assign src_rc_en  = (target == SRC_RC) || (active == SRC_RC) || wdt_en || fscm_en;

  assert_sel_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> $past(handover));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    handover |=> !handover);

  assert_stable_on_pri_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pri_stable |-> (mux_sel == SRC_PRI && pri_osc_en));

  assert_stable_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_stable) |-> $past(mux_done));

  assert_rc_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_en || fscm_en) |-> src_rc_en);

  assert_rc_stops_pri_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_sel[1]) && ($past(state) == ST_IDLE || $past(state) == ST_START ||
     $past(state) == ST_LOCK)) |-> (!pri_osc_en && !pri_stable));

endmodule

// File: tb/test_clksw_ctrl.sv
module test_clksw_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PRI_HALF   = 20;
  localparam int SEC_HALF   = 30;
  localparam int OST        = 16;
  localparam int PLL        = 20;

  logic clk, rst_n, pll_use, wdt_en, fscm_en, pri_tick, sec_tick, mux_done;
  logic [1:0] src_sel, mux_sel;
  logic pri_osc_en, sec_osc_en, pll_en, src_rc_en, handover, pri_stable;

  clksw_ctrl #(.OST_CYC(OST), .PLL_LOCK_CYC(PLL), .SYNC_STAGES(2)) i_clksw_ctrl (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pll_use(pll_use),
    .wdt_en(wdt_en), .fscm_en(fscm_en), .pri_tick(pri_tick), .sec_tick(sec_tick),
    .mux_done(mux_done), .pri_osc_en(pri_osc_en), .sec_osc_en(sec_osc_en),
    .pll_en(pll_en), .src_rc_en(src_rc_en), .mux_sel(mux_sel),
    .handover(handover), .pri_stable(pri_stable)
  );

  typedef struct {
    logic [1:0] sel;
    int         kind;   // 0 none, 1 edge count, 2 edge count plus lock
  } exp_t;

  exp_t expq[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int pri_edges = 0, sec_edges = 0, pri_mark = -1;
  logic pend = 1'b0;
  logic [1:0] pend_sel = 2'b00;
  exp_t cur;
  int   ed;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    pri_tick = 1'b0;
    forever begin
      #(PRI_HALF);
      pri_tick = pri_osc_en ? ~pri_tick : 1'b0;
    end
  end

  initial begin
    sec_tick = 1'b0;
    forever begin
      #(SEC_HALF);
      sec_tick = sec_osc_en ? ~sec_tick : 1'b0;
    end
  end

  always @(posedge pri_tick) pri_edges++;
  always @(posedge sec_tick) sec_edges++;

  // clock mux model: completes three cycles after the strobe
  initial begin
    mux_done = 1'b0;
    forever begin
      @(negedge clk);
      if (handover) begin
        repeat (3) @(negedge clk);
        mux_done = 1'b1;
        @(negedge clk);
        mux_done = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ho(input logic [1:0] sel, input int kind);
    exp_t e;
    e.sel  = sel;
    e.kind = kind;
    expq.push_back(e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (pri_edges >= OST && pri_mark < 0) pri_mark = cyc;
    if (pend) begin
      chk(mux_sel == pend_sel, "R6", "mux_sel after strobe", int'(mux_sel), int'(pend_sel));
      pend = 1'b0;
    end
    if (handover) begin
      if (expq.size() == 0) begin
        chk(0, "R6", "unexpected strobe, mux_sel", int'(mux_sel), -1);
      end else begin
        cur      = expq.pop_front();
        pend     = 1'b1;
        pend_sel = cur.sel;
        if (cur.kind == 1) begin
          ed = (cur.sel == 2'b00) ? pri_edges : sec_edges;
          chk(ed >= OST && ed <= OST + 1, "R4", "raw edges at strobe", ed, OST);
        end else if (cur.kind == 2) begin
          chk(pri_mark >= 0 && cyc - pri_mark >= PLL && cyc - pri_mark <= PLL + 6,
              "R5", "cycles from count to strobe", cyc - pri_mark, PLL);
        end
      end
    end
  end

  task automatic wait_sel(input logic [1:0] s, input string req);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (mux_sel == s && expq.size() == 0 && !handover) break;
    end
    repeat (6) @(negedge clk);
    chk(mux_sel == s, req, "mux_sel settled", int'(mux_sel), int'(s));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_sel = 2'b10; pll_use = 1'b0; wdt_en = 1'b0; fscm_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(mux_sel == 2'b10, "R1", "mux_sel in reset", int'(mux_sel), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mux_sel == 2'b10 && !handover, "R1", "mux_sel after reset", int'(mux_sel), 2);
    chk(!pri_stable && src_rc_en, "R1", "stable/rc", int'({pri_stable, src_rc_en}), 1);
    chk(!pri_osc_en && !sec_osc_en, "R1", "osc enables", int'({pri_osc_en, sec_osc_en}), 0);

    // R2: bit 0 ignored while bit 1 is set
    src_sel = 2'b11;
    repeat (20) @(negedge clk);
    chk(mux_sel == 2'b10 && !pri_osc_en && !sec_osc_en, "R2", "11 stays on RC",
        int'({mux_sel, pri_osc_en, sec_osc_en}), 8);

    // switch to primary, no PLL
    pri_edges = 0; pri_mark = -1;
    expect_ho(2'b00, 1);
    src_sel = 2'b00;
    repeat (2) @(negedge clk);
    chk(pri_osc_en && mux_sel == 2'b10, "R3", "primary on, still RC",
        int'({pri_osc_en, mux_sel}), 6);
    repeat (30) @(negedge clk);
    chk(mux_sel == 2'b10 && !pri_stable, "R4", "no switch mid count",
        int'({mux_sel, pri_stable}), 4);
    wait_sel(2'b00, "R2");
    chk(pri_stable, "R7", "stable after hand-over", int'(pri_stable), 1);

    // switch to RC: primary off at once
    expect_ho(2'b10, 0);
    src_sel = 2'b10;
    @(negedge clk);
    chk(!pri_osc_en && !pri_stable, "R3", "primary off and flag clear",
        int'({pri_osc_en, pri_stable}), 0);
    wait_sel(2'b10, "R3");

    // primary through the PLL with the watchdog on
    wdt_en = 1'b1; pll_use = 1'b1;
    pri_edges = 0; pri_mark = -1;
    expect_ho(2'b00, 2);
    src_sel = 2'b00;
    repeat (2) @(negedge clk);
    chk(pll_en && pri_osc_en, "R5", "pll enabled", int'(pll_en), 1);
    wait_sel(2'b00, "R5");
    chk(pri_stable && src_rc_en, "R8", "rc kept by watchdog", int'(src_rc_en), 1);
    wdt_en = 1'b0; fscm_en = 1'b1;
    @(negedge clk);
    chk(src_rc_en, "R8", "rc kept by monitor", int'(src_rc_en), 1);
    fscm_en = 1'b0;
    @(negedge clk);
    chk(!src_rc_en, "R8", "rc released", int'(src_rc_en), 0);
    pll_use = 1'b0;

    // secondary from primary
    sec_edges = 0;
    expect_ho(2'b01, 1);
    src_sel = 2'b01;
    repeat (20) @(negedge clk);
    chk(mux_sel == 2'b00 && pri_stable, "R4", "primary kept during count",
        int'({mux_sel, pri_stable}), 1);
    wait_sel(2'b01, "R4");
    chk(!pri_stable && !pri_osc_en && sec_osc_en, "R7", "flag cleared, primary off",
        int'({pri_stable, pri_osc_en, sec_osc_en}), 1);

    // cancel back to the source in use
    src_sel = 2'b00;
    repeat (10) @(negedge clk);
    chk(pri_osc_en, "R9", "primary started", int'(pri_osc_en), 1);
    src_sel = 2'b01;
    repeat (3) @(negedge clk);
    chk(!pri_osc_en, "R9", "primary dropped on cancel", int'(pri_osc_en), 0);
    repeat (80) @(negedge clk);
    chk(mux_sel == 2'b01, "R9", "no hand-over on cancel", int'(mux_sel), 1);

    // restart toward a new target mid count
    expect_ho(2'b10, 0);
    src_sel = 2'b10;
    wait_sel(2'b10, "R9");
    pri_edges = 0;
    src_sel = 2'b00;
    repeat (24) @(negedge clk);
    sec_edges = 0;
    expect_ho(2'b01, 1);
    src_sel = 2'b01;
    wait_sel(2'b01, "R9");
    chk(!pri_osc_en, "R9", "primary off after retarget", int'(pri_osc_en), 0);

    // change during the mux hand-over is deferred
    expect_ho(2'b10, 0);
    expect_ho(2'b01, 0);
    src_sel = 2'b10;
    for (int k = 0; k < 50; k++) begin
      if (handover) break;
      @(negedge clk);
    end
    src_sel = 2'b01;
    repeat (2) @(negedge clk);
    chk(mux_sel == 2'b10, "R10", "RC hand-over completed first", int'(mux_sel), 2);
    wait_sel(2'b01, "R10");

    chk(expq.size() == 0, "R6", "all expected strobes seen", expq.size(), 0);
    summary();
    $finish;
  end
endmodule